// File: doc/BRIEF.md
# Zero-Stall Energy-Saving Instruction Cache

This block sits between the fetch stage of a three-stage (fetch, decode, memory) microcontroller pipeline and a single-cycle flash program memory. Its goal is to save energy, not time. Every fetch is looked up in a small tag memory and a separate instruction data memory. A fetch that hits returns the stored word and keeps the flash enable low. A fetch that misses reads the flash in the same cycle, exactly as if no cache were present, so the pipeline never waits.

Words fetched from flash are gathered in a one-line staging buffer. The buffer holds a line address, one valid bit per word and the words themselves. A fetch that matches a buffered word is served from the buffer. The buffer is written into the arrays only in a cycle that does not read them: an idle fetch cycle, a cycle served by the buffer, or a miss to a different line that needs the buffer. This removes every read/write collision on the single-port arrays without dividing the clock cycle.

Line size (1 or 4 words), associativity (1, 2 or 4 ways), set count, address width and word width are parameters. Each way keeps one valid bit per word. Replacement is round-robin within each set.

Top module: `fetch_icache`

## Requirements
- R1: Every fetch request is resolved in its own cycle as exactly one of hit or miss. On a miss `flash_en_o` is high, `flash_addr_o` equals the fetch address, and `fetch_data_o` equals `flash_data_i` in that same cycle.
- R2: On a hit, `fetch_data_o` holds the word previously read from flash for that address, and `flash_en_o` stays low.
- R3: Missed words are captured in the staging buffer. Fetching a word of the buffered line that was already captured hits, including an immediate repeat of the same address.
- R4: The buffer is written into the arrays only in a cycle with no fetch request, a buffer hit, or a miss to a line other than the buffered one. It is never written in a cycle that hits the arrays.
- R5: After the buffer has been written to the arrays, the words of that line still hit after the buffer moves on to another line.
- R6: Validity is tracked per word. A word never fetched from flash misses even when other words of its line are cached. A later word of a cached line is merged into the same way without losing the earlier words.
- R7: Replacement is round-robin per set. After reset, the first line placed in a set goes to way 0, and the pointer advances by one for each new line placed in that set. The pointer does not advance when a word is merged into an existing line.
- R8: Reset clears all valid bits and empties the buffer, so the first fetch of any address after reset misses.
- R9: In a cycle with no fetch request, `hit_o`, `miss_o`, `flash_en_o` and `flash_rd_o` are all low.
- R10: `flash_rd_o` pulses exactly in the cycles that read the flash. A loop of sequential fetches that fits in the cache reads the flash once per word on its first pass and never on later passes.
- R11: If a miss allocates the buffer for a line whose way is evicted by the write-back in that same cycle, the line is treated as new. Its words are later placed by replacement, and no stale way is merged into.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_req_i | input | 1 | Fetch request from the fetch stage |
| fetch_addr_i | input | AW | Word address of the fetch |
| fetch_data_o | output | DW | Instruction word, valid in the request cycle |
| flash_en_o | output | 1 | Flash read enable, high only on a miss |
| flash_addr_o | output | AW | Flash word address |
| flash_data_i | input | DW | Flash read data, same cycle as enable |
| hit_o | output | 1 | Fetch served by buffer or arrays |
| miss_o | output | 1 | Fetch served by flash |
| flash_rd_o | output | 1 | Flash access event pulse |

## Verification
The assertions assume that the flash returns valid data combinationally in the same cycle that `flash_en_o` is raised, and that `fetch_req_i` is held low throughout reset. The repeat-fetch property also assumes that the flash contents do not change while the cache is running. The bench models the flash as a fixed function of the address and returns a poison word whenever the enable is low, so any hit wrongly taken from flash shows up in the data. It drives requests only between clock edges, from reset onward.

// File: rtl/icache_pkg.sv
package icache_pkg;
  function automatic int unsigned bits_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  typedef enum logic [1:0] {
    SRC_FLASH = 2'd0,
    SRC_BUF   = 2'd1,
    SRC_ARR   = 2'd2
  } fetch_src_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int unsigned WAYS = 2,
  parameter int unsigned SETS = 8,
  parameter int unsigned TW   = 7,
  parameter int unsigned WPL  = 4,
  localparam int unsigned IW  = icache_pkg::bits_of(SETS),
  localparam int unsigned YW  = icache_pkg::bits_of(WAYS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [IW-1:0]                 rd_idx_i,
  output logic [WAYS-1:0][TW-1:0]       rd_tag_o,
  output logic [WAYS-1:0][WPL-1:0]      rd_vld_o,
  input  logic                          wr_en_i,
  input  logic                          wr_merge_i,
  input  logic [YW-1:0]                 wr_way_i,
  input  logic [IW-1:0]                 wr_idx_i,
  input  logic [TW-1:0]                 wr_tag_i,
  input  logic [WPL-1:0]                wr_vld_i
);
  logic [TW-1:0]  tag_q [WAYS][SETS];
  logic [WPL-1:0] vld_q [WAYS][SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++)
          vld_q[w][s] <= '0;
    end else if (wr_en_i) begin
      // merge keeps words already placed in this way
      vld_q[wr_way_i][wr_idx_i] <= wr_merge_i ? (vld_q[wr_way_i][wr_idx_i] | wr_vld_i)
                                              : wr_vld_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !wr_merge_i) tag_q[wr_way_i][wr_idx_i] <= wr_tag_i;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_tag_o[w] = tag_q[w][rd_idx_i];
    assign rd_vld_o[w] = vld_q[w][rd_idx_i];
  end
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
  parameter int unsigned WAYS = 2,
  parameter int unsigned SETS = 8,
  parameter int unsigned WPL  = 4,
  parameter int unsigned DW   = 16,
  localparam int unsigned IW  = icache_pkg::bits_of(SETS),
  localparam int unsigned YW  = icache_pkg::bits_of(WAYS),
  localparam int unsigned OW  = icache_pkg::bits_of(WPL)
) (
  input  logic                      clk_i,
  input  logic [IW-1:0]             rd_idx_i,
  input  logic [OW-1:0]             rd_off_i,
  output logic [WAYS-1:0][DW-1:0]   rd_word_o,
  input  logic                      wr_en_i,
  input  logic [YW-1:0]             wr_way_i,
  input  logic [IW-1:0]             wr_idx_i,
  input  logic [WPL-1:0]            wr_mask_i,
  input  logic [WPL-1:0][DW-1:0]    wr_line_i
);
  logic [DW-1:0] mem_q [WAYS][SETS][WPL];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int k = 0; k < WPL; k++)
        if (wr_mask_i[k]) mem_q[wr_way_i][wr_idx_i][k] <= wr_line_i[k];
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_word_o[w] = mem_q[w][rd_idx_i][rd_off_i];
  end
endmodule

// File: rtl/icache_rr.sv
module icache_rr #(
  parameter int unsigned WAYS = 2,
  parameter int unsigned SETS = 8,
  localparam int unsigned IW  = icache_pkg::bits_of(SETS),
  localparam int unsigned YW  = icache_pkg::bits_of(WAYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] idx_i,
  input  logic          adv_i,
  output logic [YW-1:0] way_o
);
  logic [YW-1:0] ptr_q [SETS];

  assign way_o = ptr_q[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv_i) begin
      ptr_q[idx_i] <= (ptr_q[idx_i] == YW'(WAYS - 1)) ? '0 : ptr_q[idx_i] + 1'b1;
    end
  end
endmodule

// File: rtl/icache_line_buf.sv
module icache_line_buf #(
  parameter int unsigned LAW  = 10,
  parameter int unsigned WPL  = 4,
  parameter int unsigned DW   = 16,
  parameter int unsigned WAYS = 2,
  localparam int unsigned OW  = icache_pkg::bits_of(WPL),
  localparam int unsigned YW  = icache_pkg::bits_of(WAYS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   alloc_i,
  input  logic [LAW-1:0]         alloc_line_i,
  input  logic                   alloc_in_arr_i,
  input  logic [YW-1:0]          alloc_way_i,
  input  logic                   fill_i,
  input  logic [OW-1:0]          fill_off_i,
  input  logic [DW-1:0]          fill_word_i,
  input  logic                   commit_i,
  input  logic [YW-1:0]          commit_way_i,
  output logic                   lv_o,
  output logic [LAW-1:0]         line_o,
  output logic [WPL-1:0]         wv_o,
  output logic [WPL-1:0][DW-1:0] words_o,
  output logic                   pend_o,
  output logic                   in_arr_o,
  output logic [YW-1:0]          way_o
);
  logic [WPL-1:0] sel;
  assign sel = WPL'(1) << fill_off_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lv_o     <= 1'b0;
      line_o   <= '0;
      wv_o     <= '0;
      pend_o   <= 1'b0;
      in_arr_o <= 1'b0;
      way_o    <= '0;
    end else if (alloc_i) begin
      lv_o     <= 1'b1;
      line_o   <= alloc_line_i;
      wv_o     <= sel;
      pend_o   <= 1'b1;
      in_arr_o <= alloc_in_arr_i;
      way_o    <= alloc_way_i;
    end else begin
      if (fill_i) begin
        wv_o   <= wv_o | sel;
        pend_o <= 1'b1;
      end
      if (commit_i) begin
        pend_o   <= 1'b0;
        in_arr_o <= 1'b1;
        way_o    <= commit_way_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) words_o[fill_off_i] <= fill_word_i;
  end
endmodule

// File: rtl/fetch_icache.sv
module fetch_icache #(
  parameter int unsigned AW   = 12,
  parameter int unsigned DW   = 16,
  parameter int unsigned WPL  = 4,
  parameter int unsigned WAYS = 2,
  parameter int unsigned SETS = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fetch_req_i,
  input  logic [AW-1:0] fetch_addr_i,
  output logic [DW-1:0] fetch_data_o,
  output logic          flash_en_o,
  output logic [AW-1:0] flash_addr_o,
  input  logic [DW-1:0] flash_data_i,
  output logic          hit_o,
  output logic          miss_o,
  output logic          flash_rd_o
);
  import icache_pkg::*;

  localparam int unsigned OB  = $clog2(WPL);
  localparam int unsigned OW  = bits_of(WPL);
  localparam int unsigned IB  = $clog2(SETS);
  localparam int unsigned YW  = bits_of(WAYS);
  localparam int unsigned LAW = AW - OB;
  localparam int unsigned TW  = LAW - IB;

  logic [LAW-1:0] lk_line;
  logic [IB-1:0]  lk_idx;
  logic [TW-1:0]  lk_tag;
  logic [OW-1:0]  lk_off;

  assign lk_line = fetch_addr_i[AW-1:OB];
  assign lk_idx  = lk_line[IB-1:0];
  assign lk_tag  = lk_line[LAW-1:IB];

  if (WPL > 1) begin : g_off
    assign lk_off = fetch_addr_i[OB-1:0];
  end else begin : g_nooff
    assign lk_off = '0;
  end

  // staging buffer state
  logic                   buf_lv, buf_pend, buf_in_arr;
  logic [LAW-1:0]         buf_line;
  logic [WPL-1:0]         buf_wv;
  logic [WPL-1:0][DW-1:0] buf_words;
  logic [YW-1:0]          buf_way;
  logic [IB-1:0]          buf_idx;
  logic [TW-1:0]          buf_tag;

  assign buf_idx = buf_line[IB-1:0];
  assign buf_tag = buf_line[LAW-1:IB];

  // array read side
  logic [WAYS-1:0][TW-1:0]  arr_tag;
  logic [WAYS-1:0][WPL-1:0] arr_vld;
  logic [WAYS-1:0][DW-1:0]  arr_rd;
  logic [WAYS-1:0]          tag_match, way_hit;
  logic [YW-1:0]            found_way;
  logic [DW-1:0]            arr_word;

  always_comb begin
    tag_match = '0;
    way_hit   = '0;
    found_way = '0;
    arr_word  = '0;
    for (int w = 0; w < WAYS; w++) begin
      tag_match[w] = (|arr_vld[w]) && (arr_tag[w] == lk_tag);
      way_hit[w]   = tag_match[w] && arr_vld[w][lk_off];
      if (tag_match[w]) found_way = YW'(w);
      if (way_hit[w])   arr_word  = arr_rd[w];
    end
  end

  logic buf_match, buf_hit, arr_hit, miss, need_alloc, do_commit;
  logic [YW-1:0] victim, cmt_way;
  logic          cmt_repl, alloc_in_arr;

  assign buf_match  = buf_lv && (buf_line == lk_line);
  assign buf_hit    = fetch_req_i && buf_match && buf_wv[lk_off];
  assign arr_hit    = fetch_req_i && !buf_hit && (|way_hit);
  assign miss       = fetch_req_i && !buf_hit && !(|way_hit);
  assign need_alloc = miss && !buf_match;

  // write back only when the arrays are not being read for this fetch
  assign do_commit  = buf_pend && (!fetch_req_i || buf_hit || need_alloc);
  assign cmt_repl   = do_commit && !buf_in_arr;
  assign cmt_way    = buf_in_arr ? buf_way : victim;

  // a same-cycle eviction of the found way makes the new line fresh
  assign alloc_in_arr = (|tag_match) &&
                        !(cmt_repl && (buf_idx == lk_idx) && (victim == found_way));

  icache_tag_store #(.WAYS(WAYS), .SETS(SETS), .TW(TW), .WPL(WPL)) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lk_idx),
    .rd_tag_o   (arr_tag),
    .rd_vld_o   (arr_vld),
    .wr_en_i    (do_commit),
    .wr_merge_i (buf_in_arr),
    .wr_way_i   (cmt_way),
    .wr_idx_i   (buf_idx),
    .wr_tag_i   (buf_tag),
    .wr_vld_i   (buf_wv)
  );

  icache_data_store #(.WAYS(WAYS), .SETS(SETS), .WPL(WPL), .DW(DW)) u_data (
    .clk_i     (clk_i),
    .rd_idx_i  (lk_idx),
    .rd_off_i  (lk_off),
    .rd_word_o (arr_rd),
    .wr_en_i   (do_commit),
    .wr_way_i  (cmt_way),
    .wr_idx_i  (buf_idx),
    .wr_mask_i (buf_wv),
    .wr_line_i (buf_words)
  );

  icache_rr #(.WAYS(WAYS), .SETS(SETS)) u_rr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (buf_idx),
    .adv_i  (cmt_repl),
    .way_o  (victim)
  );

  icache_line_buf #(.LAW(LAW), .WPL(WPL), .DW(DW), .WAYS(WAYS)) u_buf (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .alloc_i        (need_alloc),
    .alloc_line_i   (lk_line),
    .alloc_in_arr_i (alloc_in_arr),
    .alloc_way_i    (found_way),
    .fill_i         (miss),
    .fill_off_i     (lk_off),
    .fill_word_i    (flash_data_i),
    .commit_i       (do_commit),
    .commit_way_i   (cmt_way),
    .lv_o           (buf_lv),
    .line_o         (buf_line),
    .wv_o           (buf_wv),
    .words_o        (buf_words),
    .pend_o         (buf_pend),
    .in_arr_o       (buf_in_arr),
    .way_o          (buf_way)
  );

  fetch_src_e src;
  always_comb begin
    if (buf_hit)      src = SRC_BUF;
    else if (arr_hit) src = SRC_ARR;
    else              src = SRC_FLASH;
    case (src)
      SRC_BUF: fetch_data_o = buf_words[lk_off];
      SRC_ARR: fetch_data_o = arr_word;
      default: fetch_data_o = flash_data_i;
    endcase
  end

  assign flash_en_o   = miss;
  assign flash_addr_o = fetch_addr_i;
  assign flash_rd_o   = miss;
  assign hit_o        = buf_hit || arr_hit;
  assign miss_o       = miss;
endmodule

// File: rtl/fetch_icache_chk.sv
module fetch_icache_chk #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fetch_req_i,
  input logic [AW-1:0] fetch_addr_i,
  input logic [DW-1:0] fetch_data_o,
  input logic          flash_en_o,
  input logic [DW-1:0] flash_data_i,
  input logic          hit_o,
  input logic          miss_o,
  input logic          flash_rd_o,
  input logic          arr_hit,
  input logic          do_commit
);
  // R1
  resolve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_i |-> (hit_o ^ miss_o));

  // R1
  miss_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (flash_en_o && fetch_data_o == flash_data_i));

  // R2
  hit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !flash_en_o);

  // R3
  refetch_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && $past(miss_o) && fetch_addr_i == $past(fetch_addr_i)) |-> hit_o);

  // R4
  commit_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_commit |-> !arr_hit);

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_req_i |-> !(flash_en_o || hit_o || miss_o || flash_rd_o));

  // R10
  flash_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_rd_o |-> (miss_o && !hit_o));
endmodule

bind fetch_icache fetch_icache_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_req_i  (fetch_req_i),
  .fetch_addr_i (fetch_addr_i),
  .fetch_data_o (fetch_data_o),
  .flash_en_o   (flash_en_o),
  .flash_data_i (flash_data_i),
  .hit_o        (hit_o),
  .miss_o       (miss_o),
  .flash_rd_o   (flash_rd_o),
  .arr_hit      (arr_hit),
  .do_commit    (do_commit)
);

// File: tb/fetch_icache_tb.sv
module fetch_icache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] data_o, flash_data;
  logic [11:0] flash_addr;
  logic        flash_en, hit, miss, flash_rd;

  int checks = 0;
  int errors = 0;
  int flash_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [15:0] model(input logic [11:0] a);
    return {a[3:0], a} ^ 16'h5A3C;
  endfunction

  // poison word when the flash is not enabled
  assign flash_data = flash_en ? model(flash_addr) : 16'hDEAD;

  fetch_icache u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .fetch_req_i  (req),
    .fetch_addr_i (addr),
    .fetch_data_o (data_o),
    .flash_en_o   (flash_en),
    .flash_addr_o (flash_addr),
    .flash_data_i (flash_data),
    .hit_o        (hit),
    .miss_o       (miss),
    .flash_rd_o   (flash_rd)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic fetch(input logic [11:0] a, input bit exp_hit, input string rq);
    @(negedge clk);
    req = 1'b1;
    addr = a;
    #2;
    chk(hit == exp_hit && miss == !exp_hit, rq, "hit/miss", {hit, miss}, {exp_hit, !exp_hit});
    chk(flash_en == !exp_hit && flash_rd == flash_en, rq, "flash enable", {flash_en, flash_rd},
        {!exp_hit, !exp_hit});
    if (!exp_hit) chk(flash_addr == a, rq, "flash address", flash_addr, a);
    chk(data_o == model(a), rq, "data", data_o, model(a));
    if (flash_rd) flash_cnt++;
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0;
    #2;
    chk(!(hit || miss || flash_en || flash_rd), "R9", "idle events", {hit, miss, flash_en, flash_rd}, 0);
  endtask

  task automatic t_reset();
    #2;
    chk(!(hit || miss || flash_en), "R8", "reset outputs", {hit, miss, flash_en}, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    fetch(12'h010, 1'b0, "R8");
  endtask

  task automatic t_refetch();
    fetch(12'h010, 1'b1, "R3");
    fetch(12'h010, 1'b1, "R2");
  endtask

  task automatic t_seq_line();
    for (int i = 1; i < 4; i++) fetch(12'h020 + 12'(i), 1'b0, "R1");
    fetch(12'h020, 1'b0, "R1");
    for (int i = 0; i < 4; i++) fetch(12'h020 + 12'(i), 1'b1, "R3");
  endtask

  task automatic t_commit_idle();
    fetch(12'h008, 1'b0, "R1");
    fetch(12'h009, 1'b0, "R1");
    idle();
    fetch(12'h00C, 1'b0, "R1");
    fetch(12'h008, 1'b1, "R5");
    fetch(12'h009, 1'b1, "R5");
    fetch(12'h00A, 1'b0, "R6");
  endtask

  task automatic t_commit_need();
    fetch(12'h018, 1'b0, "R1");
    fetch(12'h01C, 1'b0, "R4");
    fetch(12'h018, 1'b1, "R4");
  endtask

  task automatic t_round_robin();
    fetch(12'h014, 1'b0, "R7");
    idle();
    fetch(12'h034, 1'b0, "R7");
    idle();
    fetch(12'h054, 1'b0, "R7");
    idle();
    fetch(12'h034, 1'b1, "R7");
    fetch(12'h054, 1'b1, "R7");
    fetch(12'h014, 1'b0, "R7");
  endtask

  task automatic t_merge();
    fetch(12'h100, 1'b0, "R6");
    idle();
    fetch(12'h102, 1'b0, "R6");
    idle();
    fetch(12'h304, 1'b0, "R6");
    fetch(12'h100, 1'b1, "R6");
    fetch(12'h102, 1'b1, "R6");
    fetch(12'h101, 1'b0, "R6");
  endtask

  task automatic t_idle();
    idle();
    idle();
  endtask

  task automatic t_count();
    flash_cnt = 0;
    for (int i = 0; i < 8; i++) fetch(12'h0A0 + 12'(i), 1'b0, "R10");
    chk(flash_cnt == 8, "R10", "first pass flash reads", flash_cnt, 8);
    flash_cnt = 0;
    for (int i = 0; i < 8; i++) fetch(12'h0A0 + 12'(i), 1'b1, "R10");
    chk(flash_cnt == 0, "R10", "second pass flash reads", flash_cnt, 0);
  endtask

  task automatic t_evict_alloc();
    fetch(12'h03C, 1'b0, "R11");
    idle();
    fetch(12'h05C, 1'b0, "R11");
    idle();
    fetch(12'h07C, 1'b0, "R11");
    fetch(12'h03D, 1'b0, "R11");
    idle();
    fetch(12'h07C, 1'b1, "R11");
    fetch(12'h07D, 1'b0, "R11");
  endtask

  initial begin
    t_reset();
    t_refetch();
    t_seq_line();
    t_commit_idle();
    t_commit_need();
    t_round_robin();
    t_merge();
    t_idle();
    t_count();
    t_evict_alloc();
    idle();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule